// File: doc/BRIEF.md
# Setup-Frame Perfect Destination Filter

This block holds a table of sixteen 48-bit station addresses and decides, for every received frame, whether its destination address is one of them. The table is not written through registers. It is loaded in-band from a 192-byte setup frame that arrives on the transmit byte stream. A transmit stream is a setup frame when the descriptor control word of that request has its setup flag (bit 27) set. The caller taps that bit and presents it as `tx_setup` on the first byte of the stream.

The setup frame has sixteen entries of twelve bytes each, and each entry is three 32-bit words. Only the two low bytes of each word carry address data. The new table replaces the old one in a single step, and only once the last of the 192 bytes has been taken. On the receive side the block collects the first six bytes of each frame, which form the destination address. One cycle after the sixth byte it pulses a verdict. The promiscuous flag (bit 6 of the operation-mode word, presented as `promisc`) forces every verdict to accept.

Top module: `setup_addr_filter`

## Requirements
- R1: After reset every table entry is invalid, `match_valid` and `match_accept` are 0, and a frame is accepted only when `promisc` is 1.
- R2: A transmit stream is loaded only if `tx_setup` is 1 in the cycle where `tx_valid` and `tx_sof` are both 1. A complete 192-byte stream with `tx_setup` 0 leaves the table unchanged.
- R3: Setup byte index i belongs to entry i/12 at offset i%12. Address byte 0, which is the first destination byte on the receive stream, sits at offset 0. Address bytes 1, 2, 3, 4 and 5 sit at offsets 1, 4, 5, 8 and 9.
- R4: Bytes at offsets 2, 3, 6, 7, 10 and 11 have no effect on the table.
- R5: The table changes only when byte index 191 of a setup stream is taken. At that edge all sixteen entries are replaced and all become valid, so no address from the previous table survives.
- R6: A setup stream cut short by a new `tx_sof` before byte 191 leaves the previous table in force. Bytes after byte 191, up to the next `tx_sof`, are ignored.
- R7: A frame is accepted when its six destination bytes equal any valid entry. Otherwise it is rejected.
- R8: `match_valid` is 1 for exactly one cycle: the cycle after the sixth byte counted from `rx_sof` is taken. `rx_sof` restarts the count, and bytes after the sixth produce no further verdict.
- R9: If `promisc` is 1 in the cycle of the sixth destination byte, `match_accept` is 1 with that verdict.
- R10: When the sixth destination byte and setup byte 191 are taken in the same cycle, the verdict uses the table that was in force before that setup frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit byte present |
| tx_sof | input | 1 | First byte of a transmit stream |
| tx_setup | input | 1 | Setup flag (control word bit 27); sampled with `tx_sof` |
| tx_data | input | 8 | Transmit byte |
| promisc | input | 1 | Promiscuous flag (operation-mode bit 6) |
| rx_valid | input | 1 | Receive byte present |
| rx_sof | input | 1 | First byte of a received frame |
| rx_data | input | 8 | Receive byte |
| match_valid | output | 1 | One-cycle verdict strobe |
| match_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
The table commit and a destination comparison can land on the same clock edge. This happens when setup byte 191 and the sixth receive byte are taken together. The bench provokes it by running a setup frame and a receive frame in parallel, timed so that those two bytes share a cycle. The destination used belongs only to the new table, so the verdict must be a reject that comes from the old table. The same address is then sent again, and that second verdict must be an accept.

// File: rtl/sfilt_pkg.sv
package sfilt_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned OCTET_W = 8;

   typedef logic [OCTET_W-1:0] octet_t;

   typedef struct packed {
      logic strobe;
      logic pass;
   } verdict_t;
endpackage

// File: rtl/sfilt_setup_loader.sv
module sfilt_setup_loader
   import sfilt_pkg::*;
#(
   parameter int unsigned N_ENT      = 16,
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned LANES      = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               tx_valid,
   input  logic                               tx_sof,
   input  logic                               tx_setup,
   input  octet_t                             tx_data,
   output logic                               commit_o,
   output logic [N_ENT-1:0][ADDR_BYTES*8-1:0] stage_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned ADDR_W    = ADDR_BYTES * OCTET_W;
   localparam int unsigned WORDS     = ADDR_BYTES / LANES;
   localparam int unsigned ENT_BYTES = WORDS * WORD_BYTES;
   localparam int unsigned ENT_IW    = $clog2(N_ENT);
   localparam int unsigned OFF_IW    = $clog2(ENT_BYTES);

   if ((ADDR_BYTES % LANES) != 0 || LANES >= WORD_BYTES || N_ENT < 2) begin : g_bad_cfg
      $error("sfilt_setup_loader: unsupported layout parameters");
   end

   logic                           loading_q;
   logic [ENT_IW-1:0]              ent_q;
   logic [OFF_IW-1:0]              off_q;
   logic [N_ENT-1:0][ADDR_W-1:0]   stage_q;

   logic                           take;
   logic [ENT_IW-1:0]              cur_ent;
   logic [OFF_IW-1:0]              cur_off;
   logic                           addr_lane;
   logic                           last_off;
   logic                           last_ent;
   int                             lane_i;
   int                             word_i;
   int                             bidx_i;

   always_comb begin
      cur_ent   = tx_sof ? '0 : ent_q;
      cur_off   = tx_sof ? '0 : off_q;
      take      = tx_valid && (tx_sof ? tx_setup : loading_q);
      lane_i    = int'(cur_off) % int'(WORD_BYTES);
      word_i    = int'(cur_off) / int'(WORD_BYTES);
      bidx_i    = word_i * int'(LANES) + lane_i;
      addr_lane = (lane_i < int'(LANES));
      last_off  = (cur_off == OFF_IW'(ENT_BYTES - 1));
      last_ent  = (cur_ent == ENT_IW'(N_ENT - 1));
      commit_o  = take && last_off && last_ent;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loading_q <= 1'b0;
         ent_q     <= '0;
         off_q     <= '0;
         stage_q   <= '0;
      end else if (take) begin
         for (int k = 0; k < int'(ADDR_BYTES); k++) begin
            if (addr_lane && bidx_i == k)
               stage_q[cur_ent][(int'(ADDR_BYTES) - 1 - k) * 8 +: 8] <= tx_data;
         end
         if (last_off) begin
            off_q <= '0;
            ent_q <= cur_ent + 1'b1;
         end else begin
            off_q <= cur_off + 1'b1;
            ent_q <= cur_ent;
         end
         loading_q <= !commit_o;
      end else if (tx_valid && tx_sof) begin
         loading_q <= 1'b0;
      end
   end

   assign stage_o = stage_q;

   assert_off_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      off_q < OFF_IW'(ENT_BYTES));

   assert_load_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loading_q) |-> $past(tx_valid && tx_sof) || $past(commit_o));
endmodule

// File: rtl/sfilt_table.sv
module sfilt_table #(
   parameter int unsigned N_ENT  = 16,
   parameter int unsigned ADDR_W = 48
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           commit_i,
   input  logic [N_ENT-1:0][ADDR_W-1:0]   stage_i,
   output logic [N_ENT-1:0][ADDR_W-1:0]   tbl_o,
   output logic [N_ENT-1:0]               vld_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [N_ENT-1:0][ADDR_W-1:0] tbl_q;
   logic [N_ENT-1:0]             vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_q <= '0;
         vld_q <= '0;
      end else if (commit_i) begin
         tbl_q <= stage_i;
         vld_q <= '1;
      end
   end

   assign tbl_o = tbl_q;
   assign vld_o = vld_q;

   assert_all_or_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q == '0) || (vld_q == '1));

   assert_fill_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> (vld_q == '1));

   assert_hold_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(tbl_q) && $stable(vld_q));
endmodule

// File: rtl/sfilt_matcher.sv
module sfilt_matcher
   import sfilt_pkg::*;
#(
   parameter int unsigned N_ENT      = 16,
   parameter int unsigned ADDR_BYTES = 6
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               rx_valid,
   input  logic                               rx_sof,
   input  octet_t                             rx_data,
   input  logic                               promisc,
   input  logic [N_ENT-1:0][ADDR_BYTES*8-1:0] tbl_i,
   input  logic [N_ENT-1:0]                   vld_i,
   output verdict_t                           verdict_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;
   localparam int unsigned HIST_W = ADDR_W - OCTET_W;
   localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1);

   if (ADDR_BYTES < 2) begin : g_bad_cfg
      $error("sfilt_matcher: address must span at least two bytes");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [HIST_W-1:0] hist_q;
   logic [CNT_W-1:0]  cur_cnt;
   logic              take;
   logic              completing;
   logic [ADDR_W-1:0] cand;
   logic [N_ENT-1:0]  hit;
   verdict_t          verdict_q;

   always_comb begin
      cur_cnt    = rx_sof ? '0 : cnt_q;
      take       = rx_valid && (cur_cnt < CNT_W'(ADDR_BYTES));
      completing = take && (cur_cnt == CNT_W'(ADDR_BYTES - 1));
      cand       = {hist_q, rx_data};
   end

   for (genvar e = 0; e < int'(N_ENT); e++) begin : g_cmp
      assign hit[e] = vld_i[e] && (tbl_i[e] == cand);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         hist_q    <= '0;
         verdict_q <= '0;
      end else begin
         if (take) begin
            hist_q <= cand[HIST_W-1:0];
            cnt_q  <= cur_cnt + 1'b1;
         end
         verdict_q.strobe <= completing;
         verdict_q.pass   <= completing && (promisc || (|hit));
      end
   end

   assign verdict_o = verdict_q;

   assert_accept_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_q.pass |-> verdict_q.strobe);

   assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_q.strobe |=> !verdict_q.strobe);

   assert_promisc_accepts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (completing && promisc) |=> verdict_q.pass);

   assert_empty_rejects_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (completing && !promisc && vld_i == '0) |=> !verdict_q.pass);
endmodule

// File: rtl/setup_addr_filter.sv
module setup_addr_filter
   import sfilt_pkg::*;
#(
   parameter int unsigned N_ENT      = 16,
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned LANES      = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_valid,
   input  logic       tx_sof,
   input  logic       tx_setup,
   input  logic [7:0] tx_data,
   input  logic       promisc,
   input  logic       rx_valid,
   input  logic       rx_sof,
   input  logic [7:0] rx_data,
   output logic       match_valid,
   output logic       match_accept
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;

   logic                         commit;
   logic [N_ENT-1:0][ADDR_W-1:0] stage;
   logic [N_ENT-1:0][ADDR_W-1:0] tbl;
   logic [N_ENT-1:0]             vld;
   verdict_t                     verdict;

   sfilt_setup_loader #(
      .N_ENT(N_ENT), .ADDR_BYTES(ADDR_BYTES), .WORD_BYTES(WORD_BYTES), .LANES(LANES)
   ) u_loader (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_sof(tx_sof),
      .tx_setup(tx_setup), .tx_data(tx_data), .commit_o(commit), .stage_o(stage)
   );

   sfilt_table #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_table (
      .clk(clk), .rst_n(rst_n), .commit_i(commit), .stage_i(stage),
      .tbl_o(tbl), .vld_o(vld)
   );

   sfilt_matcher #(.N_ENT(N_ENT), .ADDR_BYTES(ADDR_BYTES)) u_matcher (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_data(rx_data), .promisc(promisc), .tbl_i(tbl), .vld_i(vld),
      .verdict_o(verdict)
   );

   assign match_valid  = verdict.strobe;
   assign match_accept = verdict.pass;

   assert_old_table_on_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && vld == '0 && !promisc && rx_valid) |=> !match_accept);
endmodule

// File: tb/setup_addr_filter_bench.sv
module setup_addr_filter_bench;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tx_valid, tx_sof, tx_setup;
   logic [7:0] tx_data;
   logic       promisc;
   logic       rx_valid, rx_sof;
   logic [7:0] rx_data;
   logic       match_valid, match_accept;

   int n_chk  = 0;
   int n_fail = 0;
   int model_set = -1;

   always #10 clk = ~clk;

   setup_addr_filter u_setup_addr_filter (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_sof(tx_sof),
      .tx_setup(tx_setup), .tx_data(tx_data), .promisc(promisc),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
      .match_valid(match_valid), .match_accept(match_accept)
   );

   function automatic logic [47:0] mk(input int set, input int e);
      logic [7:0] b0, b1, b2, b3, b4, b5;
      b0 = 8'(8'h02 ^ set);
      b1 = 8'(8'h10 + e);
      b2 = 8'(8'h31 + 3 * e + set);
      b3 = 8'(8'h47 ^ (e << 2));
      b4 = 8'(8'h80 + 5 * e + 16 * set);
      b5 = 8'(8'hC0 + e + 7 * set);
      return {b0, b1, b2, b3, b4, b5};
   endfunction

   function automatic logic [7:0] setup_byte(input int set, input int i);
      int e, off, lane, word;
      logic [47:0] a;
      e = i / 12; off = i % 12; lane = off % 4; word = off / 4;
      if (e >= 16) return 8'h5A;
      a = mk(set, e);
      if (lane < 2) return a[47 - 8 * (word * 2 + lane) -: 8];
      return 8'(8'hA5 ^ (off * 17) ^ e);
   endfunction

   function automatic bit expect_accept(input logic [47:0] a, input bit prom);
      if (prom) return 1'b1;
      if (model_set < 0) return 1'b0;
      for (int e = 0; e < 16; e++)
         if (mk(model_set, e) == a) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_setup(input int set, input bit flag, input int nbytes);
      for (int i = 0; i < nbytes; i++) begin
         @(negedge clk);
         tx_valid = 1'b1;
         tx_sof   = (i == 0);
         tx_setup = flag;
         tx_data  = setup_byte(set, i);
      end
      @(negedge clk);
      tx_valid = 1'b0; tx_sof = 1'b0; tx_setup = 1'b0;
      if (flag && nbytes >= 192) model_set = set;
   endtask

   task automatic send_rx(input logic [47:0] a, input bit prom, input int lead,
                          input int extra, input int dly, input string tag);
      bit exp;
      int total;
      exp = expect_accept(a, prom);
      repeat (dly) @(negedge clk);
      for (int j = 0; j < lead; j++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = (j == 0); rx_data = 8'h3C + 8'(j);
      end
      total = 6 + extra;
      for (int j = 0; j < total; j++) begin
         @(negedge clk);
         if (j == 6) begin
            chk(match_valid === 1'b1, {tag, " strobe"}, match_valid, 1);
            chk(match_accept === exp, {tag, " verdict"}, match_accept, exp);
         end else if (j > 6) begin
            chk(match_valid === 1'b0, "R8 no verdict on trailing byte", match_valid, 0);
         end
         rx_valid = 1'b1;
         rx_sof   = (j == 0);
         promisc  = prom;
         rx_data  = (j < 6) ? a[47 - 8 * j -: 8] : a[47 - 8 * (j % 6) -: 8];
      end
      @(negedge clk);
      if (extra == 0) begin
         chk(match_valid === 1'b1, {tag, " strobe"}, match_valid, 1);
         chk(match_accept === exp, {tag, " verdict"}, match_accept, exp);
      end else begin
         chk(match_valid === 1'b0, "R8 no verdict on trailing byte", match_valid, 0);
      end
      rx_valid = 1'b0; rx_sof = 1'b0; promisc = 1'b0;
      @(negedge clk);
      chk(match_valid === 1'b0, "R8 strobe lasts one cycle", match_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tx_valid = 1'b0; tx_sof = 1'b0; tx_setup = 1'b0; tx_data = '0;
      promisc = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_data = '0;
      repeat (5) @(negedge clk);
      chk(match_valid === 1'b0, "R1 reset strobe", match_valid, 0);
      chk(match_accept === 1'b0, "R1 reset accept", match_accept, 0);
      rst_n = 1'b1;

      // R1: empty table rejects, promiscuous accepts (R9)
      send_rx(mk(0, 0), 0, 0, 0, 0, "R1 empty table");
      send_rx(48'hFFFF_FFFF_FFFF, 0, 0, 0, 0, "R1 broadcast on empty table");
      send_rx(mk(0, 1), 1, 0, 0, 0, "R9 promiscuous on empty table");

      // R2: full-length stream without the setup flag is not loaded
      send_setup(0, 1'b0, 192);
      send_rx(mk(0, 0), 0, 0, 0, 0, "R2 non-setup stream ignored");

      // R3/R4/R7: load set 1, sweep every entry and every single-byte corruption
      send_setup(1, 1'b1, 192);
      for (int e = 0; e < 16; e++) begin
         send_rx(mk(1, e), 0, 0, 0, 0, "R3 R7 entry match");
         for (int b = 0; b < 6; b++) begin
            logic [47:0] bad;
            bad = mk(1, e);
            bad[47 - 8 * b -: 8] = bad[47 - 8 * b -: 8] ^ 8'h81;
            send_rx(bad, 0, 0, 0, 0, "R4 R7 corrupted byte rejected");
         end
      end
      send_rx(mk(1, 3) ^ 48'h1, 1, 0, 0, 0, "R9 promiscuous overrides miss");

      // R6: truncated setup stream leaves set 1 in force
      send_setup(2, 1'b1, 100);
      send_rx(mk(1, 5), 0, 0, 0, 0, "R6 short frame keeps old entry");
      send_rx(mk(2, 0), 0, 0, 0, 0, "R6 short frame not loaded");

      // R5/R6: overlong setup stream of set 3; tail ignored, old set gone
      send_setup(3, 1'b1, 212);
      send_rx(mk(3, 15), 0, 0, 0, 0, "R5 new table loaded");
      send_rx(mk(1, 5), 0, 0, 0, 0, "R5 old table replaced");
      send_rx(mk(3, 0), 0, 0, 0, 0, "R6 tail bytes ignored");

      // R8: restart on rx_sof and trailing bytes
      send_rx(mk(3, 7), 0, 3, 0, 0, "R8 restart on sof");
      send_rx(mk(3, 8), 0, 0, 4, 0, "R8 trailing bytes");

      // R10: commit and comparison in the same cycle
      fork
         send_setup(4, 1'b1, 192);
         send_rx(mk(4, 3), 0, 0, 0, 186, "R10 collision uses old table");
      join
      send_rx(mk(4, 3), 0, 0, 0, 0, "R10 new table after collision");
      send_rx(mk(3, 3), 0, 0, 0, 0, "R10 old table gone after collision");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule